// File: doc/BRIEF.md
# Iterative Maximal Independent Set Engine

This block finds a maximal independent set of a small undirected graph kept in its own storage. The graph is held in compressed sparse row form: a row-offset array with one entry per vertex plus one closing entry, and a column array of neighbour identifiers. While the engine is idle, a load port writes both arrays. A start pulse then launches a run of randomized rounds.

Each round draws a fresh 16-bit pseudo-random weight for every vertex that is still a candidate. Next it visits each candidate, takes its degree from two neighbouring offsets, and walks its edges to see whether any live neighbour outranks it. A candidate with no live neighbour of higher rank joins the set. Finally, the selected vertices and their neighbours leave the candidate pool, and each selected identifier is sent out on a valid/ready stream. The run ends with a one-cycle done pulse after the first round that selects nothing.

The intended use is a control-plane helper that schedules conflict-free work items. The caller loads the conflict graph, starts the engine, and drains the identifiers.

Top module: `mis_engine`

## Requirements
- R1: While `busy` is low, a cycle with `ld_en` high writes `ld_data` to row-offset entry `ld_addr` (0..64) when `ld_sel` is 0, or writes column entry `ld_addr` (0..511, low 6 bits of `ld_data`) when `ld_sel` is 1. The neighbours of vertex v are the column entries from offset[v] up to offset[v+1]-1, so its degree is offset[v+1]-offset[v].
- R2: A `start` pulse while idle makes vertices 0..num_v-1 the candidates. A `num_v` above 64 is treated as 64. The weight generator is loaded with `seed`, and a seed of zero is replaced by 1.
- R3: Weights come from a 16-bit shift register whose next state is {s[14:0], s[15]^s[13]^s[12]^s[10]}. At the start of every round, the candidates take the current state as their weight in increasing identifier order, and the register advances once after each weight is taken. The first weight of a run equals the loaded seed.
- R4: A candidate v joins the set when every neighbour u that is still a candidate has rank below v. Here u outranks v when w[u] < w[v], or when the weights are equal and u < v. Self-loop edges and neighbours that are no longer candidates are ignored.
- R5: All decisions in a round use the weights and candidate pool fixed at the start of that round. Selected vertices and all of their listed neighbours leave the pool only after every decision in the round has been made.
- R6: The identifiers selected in a round are sent on `out_id` with `out_valid` in increasing order, and rounds are sent in sequence. While `out_ready` is low, `out_valid` and `out_id` hold steady.
- R7: `busy` rises in the cycle after an accepted start. The first round that selects nothing ends the run: `done` is high for exactly one cycle after the last identifier, and `busy` then falls.
- R8: For a graph stored symmetrically, the emitted identifiers are pairwise non-adjacent, and every other vertex below num_v has an emitted neighbour.
- R9: A `start` pulse while `busy` is high has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Load strobe for graph storage |
| ld_sel | input | 1 | 0 selects the row-offset array, 1 selects the column array |
| ld_addr | input | 9 | Entry index for the load |
| ld_data | input | 10 | Load value |
| start | input | 1 | Begin a run |
| num_v | input | 7 | Number of vertices in the graph |
| seed | input | 16 | Initial weight generator state |
| busy | output | 1 | Run in progress |
| out_valid | output | 1 | Selected identifier available |
| out_ready | input | 1 | Consumer accepts the identifier |
| out_id | output | 6 | Selected vertex identifier |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The hardest case to reach from the ports is a vertex that joins the set only in a late round. That vertex must lose in every earlier round, and all of its higher-ranked neighbours must then be removed through other selections. Random graphs of medium density, many seeds and a 64-vertex ring create chains of such vertices. For each one, the bench computes the full round-by-round result from the weight recurrence. Consumer stalls are mixed in during the removal walk, so that emission under backpressure overlaps with the multi-round progress.

// File: rtl/mis_pkg.sv
// Shared types for the maximal independent set engine.
// Assumes: weight width is fixed at 16 bits to match the generator taps.
package mis_pkg;
    localparam int WT_W = 16;

    typedef enum logic [3:0] {
        S_IDLE,    // waiting for start
        S_WEIGH,   // hand out weights to candidates
        S_GATHER,  // find next candidate, read its degree
        S_EDGE,    // walk candidate edges, compare ranks
        S_UFETCH,  // find next selected vertex
        S_EMIT,    // present selected id on the output stream
        S_UEDGE,   // walk selected vertex edges, mark removals
        S_WB,      // write candidate status back
        S_FINISH   // one-cycle done
    } state_t;
endpackage

// File: rtl/mis_lfsr.sv
// Sixteen-bit maximal-length shift register used as the weight source.
// Assumes: load and step are never high together with a meaningful step;
// load wins. A zero seed is replaced by 1 so the state never locks.
module mis_lfsr
    import mis_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [WT_W-1:0] seed,
    input  logic            step,
    output logic [WT_W-1:0] state
);
    logic [WT_W-1:0] st_q;
    logic            fb;

    // feedback from taps 16, 14, 13, 11
    assign fb    = st_q[15] ^ st_q[13] ^ st_q[12] ^ st_q[10];
    assign state = st_q;

    // state register: reset, load with seed, or advance
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= {{(WT_W-1){1'b0}}, 1'b1};
        else if (load)
            st_q <= (seed == '0) ? {{(WT_W-1){1'b0}}, 1'b1} : seed;
        else if (step)
            st_q <= {st_q[WT_W-2:0], fb};
    end

    // R3: the generator never reaches the all-zero lock state
    assert_lfsr_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != '0);

    // R3: a step moves the state by exactly one shift
    assert_lfsr_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (st_q[WT_W-1:1] == $past(st_q[WT_W-2:0])));
endmodule

// File: rtl/mis_csr_store.sv
// Graph storage in compressed sparse row form: offset array of NV+1 entries
// and a column array of NE neighbour ids. Reads are combinational so the
// edge walk consumes one edge per cycle.
// Assumes: NE > NV; out-of-range offset writes are dropped.
module mis_csr_store #(
    parameter int NV = 64,
    parameter int NE = 512,
    localparam int VW  = $clog2(NV),
    localparam int EW  = $clog2(NE + 1),
    localparam int LAW = $clog2(NE)
) (
    input  logic           clk,
    input  logic           wr_en,
    input  logic           wr_sel,
    input  logic [LAW-1:0] wr_addr,
    input  logic [EW-1:0]  wr_data,
    input  logic [VW-1:0]  rd_vtx,
    input  logic [LAW-1:0] rd_eaddr,
    output logic [EW-1:0]  rd_base,
    output logic [EW-1:0]  rd_deg,
    output logic [VW-1:0]  rd_nbr
);
    localparam logic [VW:0] V_ONE = {{VW{1'b0}}, 1'b1};

    logic [EW-1:0] offs [NV+1];
    logic [VW-1:0] cols [NE];
    logic [VW:0]   vlo;
    logic [VW:0]   vhi;

    // storage write port; contents need no reset
    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (!wr_sel) begin
                if (int'(wr_addr) <= NV)
                    offs[wr_addr[VW:0]] <= wr_data;
            end else begin
                cols[wr_addr] <= wr_data[VW-1:0];
            end
        end
    end

    // degree and base of the addressed vertex, neighbour at edge address
    always_comb begin
        vlo     = {1'b0, rd_vtx};
        vhi     = vlo + V_ONE;
        rd_base = offs[vlo];
        rd_deg  = offs[vhi] - offs[vlo];
        rd_nbr  = cols[rd_eaddr];
    end
endmodule

// File: rtl/mis_rank_cmp.sv
// Rank comparison between a candidate and one neighbour: the neighbour
// outranks when its weight is lower, or equal with a lower id.
// Assumes: callers filter self-loops and removed neighbours.
module mis_rank_cmp #(
    parameter int VW = 6,
    parameter int WW = 16
) (
    input  logic [WW-1:0] own_w,
    input  logic [VW-1:0] own_id,
    input  logic [WW-1:0] nbr_w,
    input  logic [VW-1:0] nbr_id,
    output logic          nbr_wins
);
    // total order over (weight, id)
    always_comb begin
        nbr_wins = (nbr_w < own_w) || ((nbr_w == own_w) && (nbr_id < own_id));
    end
endmodule

// File: rtl/mis_engine.sv
// Iterative maximal independent set engine. Each round: weigh candidates,
// check every candidate for a local minimum over its live neighbours, then
// emit the winners while marking them and their neighbours for removal,
// then write the candidate status back. A round with no winner ends the run.
// Assumes: graph loaded while idle; symmetric storage for independence.
module mis_engine
    import mis_pkg::*;
#(
    parameter int NV = 64,
    parameter int NE = 512,
    localparam int VW  = $clog2(NV),
    localparam int EW  = $clog2(NE + 1),
    localparam int LAW = $clog2(NE)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_en,
    input  logic            ld_sel,
    input  logic [LAW-1:0]  ld_addr,
    input  logic [EW-1:0]   ld_data,
    input  logic            start,
    input  logic [VW:0]     num_v,
    input  logic [WT_W-1:0] seed,
    output logic            busy,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [VW-1:0]   out_id,
    output logic            done
);
    localparam logic [VW:0]   NV_W  = (VW+1)'(NV);
    localparam logic [VW:0]   V_ONE = {{VW{1'b0}}, 1'b1};
    localparam logic [EW-1:0] E_ONE = {{(EW-1){1'b0}}, 1'b1};

    state_t          state;
    logic [VW:0]     vi;
    logic [VW:0]     nv;
    logic [VW-1:0]   cur;
    logic [NV-1:0]   cand;
    logic [NV-1:0]   sel;
    logic [NV-1:0]   kill;
    logic [NV-1:0]   init_mask;
    logic [EW-1:0]   eptr;
    logic [EW-1:0]   rem;
    logic            lost;
    logic [VW:0]     nv_c;
    logic [WT_W-1:0] wt [NV];
    logic [WT_W-1:0] lfsr_q;
    logic            lfsr_load;
    logic            lfsr_step;
    logic [EW-1:0]   rd_base;
    logic [EW-1:0]   rd_deg;
    logic [VW-1:0]   rd_nbr;
    logic            nbr_wins;
    logic            rival;
    logic            at_end;

    assign cur    = vi[VW-1:0];
    assign at_end = (vi == nv);

    // clamp vertex count and build the initial candidate mask
    always_comb begin
        nv_c = (num_v > NV_W) ? NV_W : num_v;
        for (int i = 0; i < NV; i++)
            init_mask[i] = (i < int'(nv_c));
    end

    // generator control: load on accepted start, step per weight handed out
    assign lfsr_load = (state == S_IDLE) && start;
    assign lfsr_step = (state == S_WEIGH) && !at_end && cand[cur];

    mis_lfsr u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (lfsr_load),
        .seed  (seed),
        .step  (lfsr_step),
        .state (lfsr_q)
    );

    mis_csr_store #(.NV(NV), .NE(NE)) u_store (
        .clk      (clk),
        .wr_en    (ld_en && (state == S_IDLE)),
        .wr_sel   (ld_sel),
        .wr_addr  (ld_addr),
        .wr_data  (ld_data),
        .rd_vtx   (cur),
        .rd_eaddr (eptr[LAW-1:0]),
        .rd_base  (rd_base),
        .rd_deg   (rd_deg),
        .rd_nbr   (rd_nbr)
    );

    mis_rank_cmp #(.VW(VW), .WW(WT_W)) u_cmp (
        .own_w    (wt[cur]),
        .own_id   (cur),
        .nbr_w    (wt[rd_nbr]),
        .nbr_id   (rd_nbr),
        .nbr_wins (nbr_wins)
    );

    // a live, non-self neighbour that outranks the current candidate
    assign rival = (rd_nbr != cur) && cand[rd_nbr] && nbr_wins;

    // weight store: filled during the weigh phase, no reset needed
    always_ff @(posedge clk) begin
        if (lfsr_step)
            wt[cur] <= lfsr_q;
    end

    // round sequencer and vertex status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            vi    <= '0;
            nv    <= '0;
            cand  <= '0;
            sel   <= '0;
            kill  <= '0;
            eptr  <= '0;
            rem   <= '0;
            lost  <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (start) begin
                        nv    <= nv_c;
                        cand  <= init_mask;
                        kill  <= '0;
                        vi    <= '0;
                        state <= S_WEIGH;
                    end
                end
                S_WEIGH: begin
                    if (at_end) begin
                        vi    <= '0;
                        sel   <= '0;
                        state <= S_GATHER;
                    end else begin
                        vi <= vi + V_ONE;
                    end
                end
                S_GATHER: begin
                    if (at_end) begin
                        vi    <= '0;
                        state <= (sel == '0) ? S_FINISH : S_UFETCH;
                    end else if (!cand[cur]) begin
                        vi <= vi + V_ONE;
                    end else begin
                        eptr  <= rd_base;
                        rem   <= rd_deg;
                        lost  <= 1'b0;
                        state <= S_EDGE;
                    end
                end
                S_EDGE: begin
                    if (rem == '0) begin
                        sel[cur] <= !lost;
                        vi       <= vi + V_ONE;
                        state    <= S_GATHER;
                    end else begin
                        if (rival)
                            lost <= 1'b1;
                        eptr <= eptr + E_ONE;
                        rem  <= rem - E_ONE;
                    end
                end
                S_UFETCH: begin
                    if (at_end)
                        state <= S_WB;
                    else if (!sel[cur])
                        vi <= vi + V_ONE;
                    else
                        state <= S_EMIT;
                end
                S_EMIT: begin
                    if (out_ready) begin
                        kill[cur] <= 1'b1;
                        eptr      <= rd_base;
                        rem       <= rd_deg;
                        state     <= S_UEDGE;
                    end
                end
                S_UEDGE: begin
                    if (rem == '0) begin
                        vi    <= vi + V_ONE;
                        state <= S_UFETCH;
                    end else begin
                        kill[rd_nbr] <= 1'b1;
                        eptr         <= eptr + E_ONE;
                        rem          <= rem - E_ONE;
                    end
                end
                S_WB: begin
                    cand  <= cand & ~kill;
                    kill  <= '0;
                    vi    <= '0;
                    state <= S_WEIGH;
                end
                S_FINISH: state <= S_IDLE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    assign busy      = (state != S_IDLE);
    assign out_valid = (state == S_EMIT);
    assign out_id    = cur;
    assign done      = (state == S_FINISH);

    // R6: a stalled output holds its identifier
    assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_id)));

    // R7: done lasts a single cycle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: an emitted vertex is still in the candidate pool of its round
    assert_emit_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> cand[out_id]);

    // R5: the pool changes only in the write-back step or at start
    assert_pool_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_WB && state != S_IDLE) |=> $stable(cand));

    // R9: the vertex count of a run is not changed by a start while busy
    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(nv));
endmodule

// File: tb/mis_engine_bench.sv
`timescale 1ns/1ps
module mis_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic        ld_sel = 1'b0;
    logic [8:0]  ld_addr = '0;
    logic [9:0]  ld_data = '0;
    logic        start = 1'b0;
    logic [6:0]  num_v = '0;
    logic [15:0] seed = 16'h1;
    logic        busy;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [5:0]  out_id;
    logic        done;

    int checks = 0;
    int errors = 0;

    bit adj [64][64];
    int g_off [65];
    int g_col [512];
    int g_ne;
    int exp_ids [64];
    int exp_n;
    int got [64];
    int got_n;
    int done_cnt;
    int done_long;
    bit done_prev;
    bit bp_mode;

    always #5 clk = ~clk;

    mis_engine u_mis_engine (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_addr(ld_addr), .ld_data(ld_data), .start(start), .num_v(num_v),
        .seed(seed), .busy(busy), .out_valid(out_valid), .out_ready(out_ready),
        .out_id(out_id), .done(done)
    );

    // consumer and monitor, away from the active edge
    always @(negedge clk) begin
        out_ready = bp_mode ? (($urandom % 3) != 0) : 1'b1;
        if (out_valid && out_ready && got_n < 64) begin
            got[got_n] = int'(out_id);
            got_n++;
        end
        if (done) done_cnt++;
        if (done && done_prev) done_long++;
        done_prev = done;
    end

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int lfsr_next(int s);
        int b;
        b = ((s >> 15) ^ (s >> 13) ^ (s >> 12) ^ (s >> 10)) & 1;
        return ((s << 1) & 16'hfffe) | b;
    endfunction

    task automatic clear_adj();
        for (int a = 0; a < 64; a++)
            for (int b = 0; b < 64; b++) adj[a][b] = 1'b0;
    endtask

    task automatic add_edge(int a, int b);
        adj[a][b] = 1'b1;
        adj[b][a] = 1'b1;
    endtask

    task automatic build_csr();
        int e;
        e = 0;
        for (int v = 0; v < 64; v++) begin
            g_off[v] = e;
            for (int u = 0; u < 64; u++)
                if (adj[v][u] && e < 512) begin
                    g_col[e] = u;
                    e++;
                end
        end
        g_off[64] = e;
        g_ne = e;
    endtask

    task automatic wr(bit s, int a, int d);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = s; ld_addr = 9'(a); ld_data = 10'(d);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic load_graph();
        build_csr();
        for (int i = 0; i <= 64; i++) wr(1'b0, i, g_off[i]);
        for (int i = 0; i < g_ne; i++) wr(1'b1, i, g_col[i]);
    endtask

    // full round-by-round expected result from the stated rules
    task automatic model(int nvin, int sd);
        bit c [64];
        bit s [64];
        bit k [64];
        int w [64];
        int lf;
        int n;
        bit any;
        bit win;
        n = (nvin > 64) ? 64 : nvin;
        lf = sd & 16'hffff;
        if (lf == 0) lf = 1;
        exp_n = 0;
        for (int v = 0; v < 64; v++) c[v] = (v < n);
        for (int r = 0; r < 70; r++) begin
            for (int v = 0; v < n; v++)
                if (c[v]) begin w[v] = lf; lf = lfsr_next(lf); end
            any = 1'b0;
            for (int v = 0; v < n; v++) begin
                s[v] = 1'b0;
                k[v] = 1'b0;
                if (c[v]) begin
                    win = 1'b1;
                    for (int e = g_off[v]; e < g_off[v+1]; e++) begin
                        int u;
                        u = g_col[e];
                        if (u != v && c[u] && (w[u] < w[v] || (w[u] == w[v] && u < v)))
                            win = 1'b0;
                    end
                    s[v] = win;
                    if (win) any = 1'b1;
                end
            end
            if (!any) break;
            for (int v = 0; v < n; v++)
                if (s[v]) begin
                    exp_ids[exp_n] = v;
                    exp_n++;
                    k[v] = 1'b1;
                    for (int e = g_off[v]; e < g_off[v+1]; e++) k[g_col[e]] = 1'b1;
                end
            for (int v = 0; v < 64; v++) if (k[v]) c[v] = 1'b0;
        end
    endtask

    task automatic run_case(string tag, int nvin, int sd, int model_nv,
                            bit bp, bit restart);
        int t;
        int n;
        model(model_nv, sd);
        got_n = 0; done_cnt = 0; done_long = 0; bp_mode = bp;
        @(negedge clk);
        num_v = 7'(nvin); seed = 16'(sd); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R7", {tag, " busy after start"}, int'(busy), 1);
        if (restart) begin
            repeat (3) @(negedge clk);
            num_v = 7'd2; seed = 16'h5a5a; start = 1'b1;   // R9 stray start
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (done_cnt == 0 && t < 60000) begin
            @(negedge clk);
            t++;
        end
        chk(done_cnt > 0, "R7", {tag, " done seen"}, done_cnt, 1);
        repeat (2) @(negedge clk);
        chk(done_cnt == 1 && done_long == 0, "R7", {tag, " done single pulse"},
            done_cnt + done_long, 1);
        chk(busy == 1'b0, "R7", {tag, " idle after done"}, int'(busy), 0);
        chk(got_n == exp_n, restart ? "R9" : "R6", {tag, " output count"}, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++)
            chk(got[i] == exp_ids[i], "R4", {tag, " id order"}, got[i], exp_ids[i]);
        // R8 independence and maximality from the adjacency
        n = (model_nv > 64) ? 64 : model_nv;
        begin
            bit in_set [64];
            int bad;
            bad = 0;
            for (int v = 0; v < 64; v++) in_set[v] = 1'b0;
            for (int i = 0; i < got_n; i++) in_set[got[i]] = 1'b1;
            for (int a = 0; a < n; a++)
                for (int b = 0; b < n; b++)
                    if (a != b && in_set[a] && in_set[b] && adj[a][b]) bad++;
            chk(bad == 0, "R8", {tag, " independent"}, bad, 0);
            bad = 0;
            for (int a = 0; a < n; a++)
                if (!in_set[a]) begin
                    bit cov;
                    cov = 1'b0;
                    for (int b = 0; b < n; b++)
                        if (b != a && in_set[b] && adj[a][b]) cov = 1'b1;
                    if (!cov) bad++;
                end
            chk(bad == 0, "R8", {tag, " maximal"}, bad, 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && out_valid == 0 && done == 0, "R7", "reset state",
            int'(busy) + int'(out_valid) + int'(done), 0);

        // R2 empty graph: done with no output
        clear_adj(); load_graph();
        run_case("R2 zero vertices", 0, 16'h0001, 0, 1'b0, 1'b0);

        // R4 isolated vertices all win in the first round
        run_case("R4 isolated", 10, 16'h1234, 10, 1'b0, 1'b0);
        chk(got_n == 10, "R4", "isolated all chosen", got_n, 10);

        // R1 complete graph of six: exactly one winner
        clear_adj();
        for (int a = 0; a < 6; a++) for (int b = a + 1; b < 6; b++) add_edge(a, b);
        load_graph();
        run_case("R1 complete6", 6, 16'hbeef, 6, 1'b0, 1'b0);
        chk(got_n == 1, "R1", "complete graph single winner", got_n, 1);

        // R4 star with self-loops everywhere
        clear_adj();
        for (int a = 1; a < 8; a++) add_edge(0, a);
        for (int a = 0; a < 8; a++) adj[a][a] = 1'b1;
        load_graph();
        run_case("R4 star selfloop", 8, 16'h0007, 8, 1'b1, 1'b0);

        // R3 seed zero behaves as seed one
        clear_adj();
        for (int a = 0; a < 4; a++) add_edge(a, a + 1);
        load_graph();
        run_case("R3 seed zero", 5, 0, 5, 1'b0, 1'b0);
        chk(got[0] == exp_ids[0], "R3", "zero seed first id", got[0], exp_ids[0]);

        // R6 ring of 64 under backpressure; R2 clamp with num_v 100
        clear_adj();
        for (int a = 0; a < 64; a++) add_edge(a, (a + 1) % 64);
        load_graph();
        run_case("R6 ring64 bp", 64, 16'hace1, 64, 1'b1, 1'b0);
        run_case("R2 clamp100", 100, 16'h0f0f, 64, 1'b0, 1'b0);

        // R9 stray start in the middle of a run
        run_case("R9 restart", 64, 16'h3c3c, 64, 1'b0, 1'b1);

        // R5 random graphs of medium density, several seeds
        for (int g = 0; g < 10; g++) begin
            int n;
            n = 12 + int'($urandom % 19);
            clear_adj();
            for (int a = 0; a < n; a++)
                for (int b = a + 1; b < n; b++)
                    if (($urandom % 100) < 25) add_edge(a, b);
            load_graph();
            for (int s = 0; s < 3; s++)
                run_case("R5 random", n, int'($urandom % 65536), n, (s % 2) == 1, 1'b0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule